// File: doc/BRIEF.md
# Inhibitable Cycle Counter with Overflow Reporting

This block is the cycle counter of the performance monitor in an I/O address translation unit. It holds a 63-bit count that advances by one on every clock. Software can read and write it through a single-cycle register port, and can freeze it with an inhibit bit. The top bit of the cycles register is a sticky overflow flag and is not part of the count.

When the count rolls over from all ones to zero, the overflow is reported in two places: the flag in the cycles register and bit 0 of a shared overflow-summary register. A one-cycle interrupt request is raised only if the summary bit was clear before the rollover, so later rollovers do not signal again until software acknowledges. Software acknowledges by writing the cycles register with the flag bit at 0, which also clears the summary bit.

Run control is a two-state machine. `ST_COUNT` is entered at reset; in it the counter advances. `ST_HALT` holds the count. Transition `T_STOP` (`ST_COUNT` to `ST_HALT`) is taken on a write of 1 to the inhibit bit. Transition `T_RESUME` (`ST_HALT` to `ST_COUNT`) is taken on a write of 0. Any other cycle keeps the current state.

Top module: `perf_cycle_counter`

## Requirements
- R1: While the inhibit bit is clear, the count field (bits [CNT_W-1:0] of the cycles register, select code 0) increases by exactly one per clock, modulo 2^CNT_W.
- R2: The inhibit bit is bit 0 of the inhibit register (select code 1) and reads back as written. While it is set the count holds. When it is cleared, counting resumes from the held value. A new inhibit value governs counting from the clock after the write, so the clock edge of the write itself still counts under the old value.
- R3: On a rollover of the count from all ones to zero, the overflow flag (bit CNT_W of the cycles register) becomes 1 and summary bit 0 (select code 2) becomes 1.
- R4: `irq` is high for exactly the one cycle that follows a rollover edge, and only if summary bit 0 was 0 before that edge. Otherwise it stays low.
- R5: A write to the cycles register with bit CNT_W at 0 clears both the overflow flag and summary bit 0. A write with bit CNT_W at 1 sets the flag and leaves the summary bit unchanged.
- R6: A write to the cycles register loads the count field from wr_data[CNT_W-1:0], and counting continues from that value. The write takes priority over the increment of that clock, so that clock produces no rollover, flag, summary change or interrupt.
- R7: Writes to the summary register (select 2) and to select code 3 change nothing. Select code 3 reads as zero, and the inhibit and summary registers read zero in all bits above bit 0.
- R8: After reset, the count, flag, inhibit bit, summary bit and `irq` are all zero, and the counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Write target: 0 cycles, 1 inhibit, 2 summary, 3 none |
| wr_data | input | CNT_W+1 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | CNT_W+1 | Combinational read data of the selected register |
| irq | output | 1 | One-cycle performance-monitor interrupt request |

## Verification
A software write can land on the same clock edge as a rollover, and that collision is what the bench works hardest to provoke. With a 4-bit count, the bench preloads every count value with both flag settings and both summary states, then runs across the rollover. It also places a cycles write, and separately an inhibit write, exactly on the edge where the count is all ones. A reference model kept in the bench from the requirements decides the outcome: a load suppresses the rollover and the interrupt, while an inhibit write still lets the rollover happen. The interrupt line is compared on every cycle so that a missing, repeated or stretched pulse is caught.

// File: rtl/perf_cyc_pkg.sv
package perf_cyc_pkg;

    typedef enum logic [1:0] {
        SEL_CYCLES  = 2'd0,
        SEL_INHIBIT = 2'd1,
        SEL_SUMMARY = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_HALT  = 1'b1
    } run_state_e;

endpackage

// File: rtl/cyc_run_fsm.sv
module cyc_run_fsm
    import perf_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inh_wr,
    input  logic inh_val,
    output logic run,
    output logic inh_bit
);

    run_state_e state_q;
    run_state_e state_d;

    // Next-state logic: T_STOP and T_RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (inh_wr && inh_val)  state_d = ST_HALT;
            ST_HALT:  if (inh_wr && !inh_val) state_d = ST_COUNT;
            default:  state_d = ST_COUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        run     = 1'b0;
        inh_bit = 1'b0;
        unique case (state_q)
            ST_COUNT: run     = 1'b1;
            ST_HALT:  inh_bit = 1'b1;
            default:  run     = 1'b0;
        endcase
    end

    // R2: inhibit bit follows the last value written to it
    p_inh_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inh_wr |=> (inh_bit == $past(inh_val)));

    // R2: without a write the run state stays put
    p_inh_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_wr |=> $stable(inh_bit));

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count_q <= '0;
        else if (load) count_q <= load_val;
        else if (run)  count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign wrap  = run && !load && (count_q == CNT_MAX);

    // R1: one step per clock while running
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R2: held while inhibited
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    // R6: a load wins over the increment
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    // R3: a rollover lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

endmodule

// File: rtl/cyc_ovf_report.sv
module cyc_ovf_report (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic flag_wr,
    input  logic flag_val,
    output logic of_flag,
    output logic summary,
    output logic irq
);

    logic of_q;
    logic sum_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            of_q  <= 1'b0;
            sum_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (flag_wr) begin
                of_q <= flag_val;
                if (!flag_val) sum_q <= 1'b0;
            end else if (wrap) begin
                of_q  <= 1'b1;
                sum_q <= 1'b1;
                irq_q <= !sum_q;
            end
        end
    end

    assign of_flag = of_q;
    assign summary = sum_q;
    assign irq     = irq_q;

    // R3: rollover raises flag and summary
    p_wrap_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (of_flag && summary));

    // R4: no request when summary was already set
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && summary) |=> !irq);

    // R4: request only ever follows a rollover
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> !irq);

    // R4: single-cycle pulse
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: acknowledge clears summary
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_val) |=> (!summary && !of_flag));

    // R5: writing the flag as 1 leaves summary alone
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_val) |=> (of_flag && $stable(summary)));

endmodule

// File: rtl/perf_cycle_counter.sv
module perf_cycle_counter
    import perf_cyc_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W:0]   wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W:0]   rd_data,
    output logic             irq
);

    localparam int DW = CNT_W + 1;

    reg_sel_e         wsel;
    reg_sel_e         rsel;
    logic             cyc_wr;
    logic             inh_wr;
    logic             run;
    logic             inh_bit;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             of_flag;
    logic             summary;

    assign wsel   = reg_sel_e'(wr_sel);
    assign rsel   = reg_sel_e'(rd_sel);
    assign cyc_wr = wr_en && (wsel == SEL_CYCLES);
    assign inh_wr = wr_en && (wsel == SEL_INHIBIT);

    cyc_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .inh_wr  (inh_wr),
        .inh_val (wr_data[0]),
        .run     (run),
        .inh_bit (inh_bit)
    );

    cyc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (cyc_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .count    (count),
        .wrap     (wrap)
    );

    cyc_ovf_report u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .flag_wr  (cyc_wr),
        .flag_val (wr_data[CNT_W]),
        .of_flag  (of_flag),
        .summary  (summary),
        .irq      (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_CYCLES:  rd_data = {of_flag, count};
            SEL_INHIBIT: rd_data = {{(DW-1){1'b0}}, inh_bit};
            SEL_SUMMARY: rd_data = {{(DW-1){1'b0}}, summary};
            SEL_NONE:    rd_data = '0;
            default:     rd_data = '0;
        endcase
    end

    // R7: summary register cannot be written directly
    p_sum_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wsel == SEL_SUMMARY)) |=> $stable(summary));

    // R8: counter runs out of reset
    p_reset_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> run);

endmodule

// File: tb/perf_cycle_counter_test.sv
module perf_cycle_counter_test;

    localparam int CW       = 4;
    localparam int PERIOD   = 10;
    localparam int DW       = CW + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model
    logic [CW-1:0] m_cnt;
    logic          m_of, m_sum, m_inh, m_irq;

    perf_cycle_counter #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= '0; m_of <= 0; m_sum <= 0; m_inh <= 0; m_irq <= 0;
        end else begin
            m_irq <= 1'b0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cnt <= wr_data[CW-1:0];
                m_of  <= wr_data[CW];
                if (!wr_data[CW]) m_sum <= 1'b0;
            end else if (!m_inh) begin
                m_cnt <= m_cnt + 1'b1;
                if (m_cnt == CMAX) begin
                    m_of  <= 1'b1;
                    m_sum <= 1'b1;
                    m_irq <= !m_sum;
                end
            end
            if (wr_en && wr_sel == 2'd1) m_inh <= wr_data[0];
        end
    end

    // R4: interrupt line compared every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R4 irq: actual %0b expected %0b at %0t", irq, m_irq, $time);
            end
        end
    end

    task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reads all registers; called just after a negedge
    task automatic check_all(input string tag);
        rd_sel = 2'd0; #1; cmp({tag, " cycles"}, rd_data, {m_of, m_cnt});
        rd_sel = 2'd1; #1; cmp({tag, " inhibit"}, rd_data, {{(DW-1){1'b0}}, m_inh});
        rd_sel = 2'd2; #1; cmp({tag, " summary"}, rd_data, {{(DW-1){1'b0}}, m_sum});
        rd_sel = 2'd0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        check_all("R8 reset");
        rd_sel = 2'd0; #1; cmp("R8 irq", {{(DW-1){1'b0}}, irq}, '0);

        // R1 free run through several rollovers (R3, R4)
        for (int i = 0; i < 40; i++) begin
            step(1);
            check_all("R1 run");
        end

        // R5 R6 sweep: every preload, both flag values, then across rollover
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 2; f++) begin
                for (int v = 0; v < (1 << CW); v++) begin
                    wr(2'd0, {f[0], v[CW-1:0]});
                    check_all("R6 load");
                    for (int k = 0; k < (1 << CW) + 1; k++) begin
                        step(1);
                        check_all("R3 after load");
                    end
                    if (s == 1) begin
                        wr(2'd0, {1'b0, v[CW-1:0]});
                        check_all("R5 ack");
                    end
                end
            end
        end

        // R2 inhibit sweep
        for (int k = 0; k < (1 << CW); k++) begin
            wr(2'd1, {{(DW-1){1'b0}}, 1'b1});
            check_all("R2 stop");
            step(k);
            check_all("R2 held");
            wr(2'd1, '0);
            check_all("R2 resume");
            step(3);
            check_all("R2 counting");
        end

        // R6 collision: load on the all-ones edge, no rollover
        wr(2'd0, {1'b0, CMAX - 1'b1});
        step(1);
        check_all("R6 pre");
        wr(2'd0, {1'b0, 4'd3});
        check_all("R6 collide");
        step(2);
        check_all("R6 after");

        // R2 collision: inhibit on the all-ones edge, rollover still happens
        wr(2'd0, {1'b0, CMAX - 1'b1});
        step(1);
        wr(2'd1, {{(DW-1){1'b0}}, 1'b1});
        check_all("R2 collide");
        step(5);
        check_all("R2 collide held");
        wr(2'd1, '0);

        // R7 summary and unused select are not writable
        wr(2'd0, '0);
        wr(2'd2, '1);
        check_all("R7 summary write");
        wr(2'd3, '1);
        check_all("R7 sel3 write");
        rd_sel = 2'd3; #1; cmp("R7 sel3 read", rd_data, '0);
        rd_sel = 2'd0;
        step(20);
        wr(2'd2, '0);
        check_all("R7 summary stays set");

        step(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule